// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits on a simple 32-bit register bus. Software picks a direction for each pin on its own. An output pin is driven from an output data register. That register can be loaded whole, or single bits can be raised or lowered through dedicated set and clear addresses, so no read-modify-write is needed. Input pins pass through a two-flop synchronizer. The synchronized value can be read back, and it feeds an edge detector.

Each pin records a pending flag on the edge direction chosen for it. Flags are cleared by writing 1. The flags that are enabled are ORed into one level-sensitive interrupt request. One pin, chosen by a select field, also produces a single-cycle trigger pulse for an external timer. Reads are combinational from the word address. Writes take effect on the clock edge, and each register field is only updated through the byte lane that holds it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), the output data register, edge select, interrupt enable, pending flags and trigger select are 0, `irq` is low and `trig` is low.
- R2: Word address 0 holds the direction register (bit n = 1 makes pin n an output, mirrored on `pin_oe`). Word address 1 holds the output data register, which is readable and drives `pin_out`.
- R3: Writing to word address 2 sets to 1 every output data bit whose write data bit is 1 and leaves the other bits unchanged. This address reads as 0.
- R4: Writing to word address 3 clears to 0 every output data bit whose write data bit is 1 and leaves the other bits unchanged. This address reads as 0.
- R5: Word address 4 reads the pin inputs through a two-flop synchronizer. A change applied before clock edge k is visible after edge k+1 and not after edge k.
- R6: Word address 5 is the edge select (bit n = 0: rising edge, 1: falling edge). A synchronized edge of the chosen direction sets bit n of the pending register at word address 7. An edge of the other direction does not set it. A pin change before edge k sets the flag at edge k+2.
- R7: Pending flags are write-1-to-clear, and zero bits in the write data have no effect. When an edge event and a clear of the same bit occur at the same clock edge, the flag stays set.
- R8: Word address 6 is the interrupt enable. `irq` is high exactly while the bitwise AND of the pending flags and the enables is nonzero.
- R9: Word address 8 bits [2:0] select a pin. An event on that pin (per its edge select) makes `trig` high for exactly the one cycle after edge k+2.
- R10: Per-pin fields and the trigger select sit in byte lane 0, and a write with `bus_strb[0]` = 0 changes none of them. Word addresses above 8 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables (1 = drive) |
| irq | output | 1 | Level-sensitive interrupt request |
| trig | output | 1 | One-cycle timer trigger pulse |

## Verification
The bench builds the block with its default parameters: eight pins, a two-stage synchronizer, a four-bit word address and a 32-bit data bus. These values put every register, every pin and the whole three-bit trigger select range within reach. With a 32-bit bus, strobes for the three upper byte lanes can be driven to show that only lane 0 writes the per-pin fields. Because the synchronizer depth is fixed at two, the exact cycle of the input readback, the pending flag and the trigger pulse can be checked. That same timing lines up an edge event with a write-1-to-clear at the same clock edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned WA_DIR  = 0;
    localparam int unsigned WA_OUT  = 1;
    localparam int unsigned WA_SET  = 2;
    localparam int unsigned WA_CLR  = 3;
    localparam int unsigned WA_IN   = 4;
    localparam int unsigned WA_FALL = 5;
    localparam int unsigned WA_IEN  = 6;
    localparam int unsigned WA_PEND = 7;
    localparam int unsigned WA_TSEL = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_in,
    input  logic [NUM_PINS-1:0] fall_sel,
    input  logic [NUM_PINS-1:0] pend_clr,
    input  logic [SEL_W-1:0]    tsel,
    output logic [NUM_PINS-1:0] pend,
    output logic                trig
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] pend;
        logic                trig;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NUM_PINS-1:0] evt;

    always_comb begin
        evt        = (~fall_sel & sync_in & ~st_q.prev)
                   | ( fall_sel & ~sync_in & st_q.prev);
        st_d       = st_q;
        st_d.prev  = sync_in;
        st_d.pend  = (st_q.pend & ~pend_clr) | evt;
        st_d.trig  = evt[tsel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign trig = st_q.trig;

    // R9: the trigger never lasts two cycles
    p_trig_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R7: with no clear written, no pending flag is lost
    p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr == '0) |=> ((pend & $past(pend)) == $past(pend)));

    // R7: a flag being cleared while its event arrives survives
    p_clr_race_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_clr & evt) != '0) |=> ((pend & $past(pend_clr & evt)) == $past(pend_clr & evt)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_strb,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] sync_in,
    input  logic [NUM_PINS-1:0] pend,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] out,
    output logic [NUM_PINS-1:0] fall_sel,
    output logic [NUM_PINS-1:0] ien,
    output logic [SEL_W-1:0]    tsel,
    output logic [NUM_PINS-1:0] pend_clr
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] fall;
        logic [NUM_PINS-1:0] ien;
        logic [SEL_W-1:0]    tsel;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [NUM_PINS-1:0] lane_m;
    logic [NUM_PINS-1:0] wbits;
    logic                wr_en;
    int unsigned         widx;

    generate
        for (genvar b = 0; b < NUM_PINS; b++) begin : g_lane
            assign lane_m[b] = bus_strb[b/8];
        end
    endgenerate

    logic unused_bus;
    assign unused_bus = ^{bus_wdata[DATA_W-1:NUM_PINS], bus_strb};

    assign wr_en = bus_sel & bus_wr;
    assign widx  = int'(bus_addr);
    assign wbits = bus_wdata[NUM_PINS-1:0] & lane_m;

    always_comb begin
        rg_d     = rg_q;
        pend_clr = '0;
        if (wr_en) begin
            case (widx)
                WA_DIR:  rg_d.dir  = (rg_q.dir  & ~lane_m) | wbits;
                WA_OUT:  rg_d.out  = (rg_q.out  & ~lane_m) | wbits;
                WA_SET:  rg_d.out  = rg_q.out | wbits;
                WA_CLR:  rg_d.out  = rg_q.out & ~wbits;
                WA_FALL: rg_d.fall = (rg_q.fall & ~lane_m) | wbits;
                WA_IEN:  rg_d.ien  = (rg_q.ien  & ~lane_m) | wbits;
                WA_PEND: pend_clr  = wbits;
                WA_TSEL: if (bus_strb[0]) rg_d.tsel = bus_wdata[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (widx)
            WA_DIR:  bus_rdata[NUM_PINS-1:0] = rg_q.dir;
            WA_OUT:  bus_rdata[NUM_PINS-1:0] = rg_q.out;
            WA_IN:   bus_rdata[NUM_PINS-1:0] = sync_in;
            WA_FALL: bus_rdata[NUM_PINS-1:0] = rg_q.fall;
            WA_IEN:  bus_rdata[NUM_PINS-1:0] = rg_q.ien;
            WA_PEND: bus_rdata[NUM_PINS-1:0] = pend;
            WA_TSEL: bus_rdata[SEL_W-1:0]    = rg_q.tsel;
            default: ;
        endcase
    end

    assign dir      = rg_q.dir;
    assign out      = rg_q.out;
    assign fall_sel = rg_q.fall;
    assign ien      = rg_q.ien;
    assign tsel     = rg_q.tsel;

    // R3: bits written to the set address end up high
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == WA_SET) |=> ((out & $past(wbits)) == $past(wbits)));

    // R4: bits written to the clear address end up low
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == WA_CLR) |=> ((out & $past(wbits)) == '0));

    // R2: direction only moves on a direction write
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && widx == WA_DIR) |=> $stable(dir));

    // R10: a write with lane 0 strobe low leaves the per-pin fields alone
    p_lane_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_strb[0]) |=> ($stable(dir) && $stable(out) && $stable(fall_sel)
                                    && $stable(ien) && $stable(tsel)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_strb,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq,
    output logic                trig
);
    localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] sync_in;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] fall_sel;
    logic [NUM_PINS-1:0] ien;
    logic [NUM_PINS-1:0] pend_clr;
    logic [SEL_W-1:0]    tsel;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_strb  (bus_strb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_in),
        .pend      (pend),
        .dir       (pin_oe),
        .out       (pin_out),
        .fall_sel  (fall_sel),
        .ien       (ien),
        .tsel      (tsel),
        .pend_clr  (pend_clr)
    );

    gpio_edge #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .fall_sel (fall_sel),
        .pend_clr (pend_clr),
        .tsel     (tsel),
        .pend     (pend),
        .trig     (trig)
    );

    assign irq = |(pend & ien);

    // R8: a raised request always has an enabled flag behind it one cycle on
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pend_clr == '0 && !(bus_sel && bus_wr)) |=> irq);
endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq, trig;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq), .trig(trig)
    );

    // behavioural reference state
    logic [7:0] m_dir = 0, m_out = 0, m_fall = 0, m_ien = 0, m_pend = 0;
    logic [7:0] m_s1 = 0, m_s2 = 0, m_prev = 0;
    int         m_tsel = 0;
    logic       m_trig = 0;

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return {24'h0, m_dir};
            1: return {24'h0, m_out};
            4: return {24'h0, m_s2};
            5: return {24'h0, m_fall};
            6: return {24'h0, m_ien};
            7: return {24'h0, m_pend};
            8: return m_tsel;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [7:0] evt, clr, lm, w;
        cyc++;
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_fall = 0; m_ien = 0; m_pend = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_tsel = 0; m_trig = 0;
        end else begin
            lm  = bus_strb[0] ? 8'hFF : 8'h00;
            w   = bus_wdata[7:0] & lm;
            clr = 0;
            for (int i = 0; i < 8; i++) begin
                if (m_fall[i]) evt[i] = m_prev[i] && !m_s2[i];
                else           evt[i] = !m_prev[i] && m_s2[i];
            end
            if (bus_sel && bus_wr && bus_addr == 7) clr = w;
            m_trig = evt[m_tsel];
            m_pend = (m_pend & ~clr) | evt;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    0: m_dir  = (m_dir & ~lm) | w;
                    1: m_out  = (m_out & ~lm) | w;
                    2: m_out  = m_out | w;
                    3: m_out  = m_out & ~w;
                    5: m_fall = (m_fall & ~lm) | w;
                    6: m_ien  = (m_ien & ~lm) | w;
                    8: if (bus_strb[0]) m_tsel = int'(bus_wdata[2:0]);
                    default: ;
                endcase
            end
        end
        #1;
        if (rst_n) begin
            check("R2 pin_oe", {24'h0, pin_oe}, {24'h0, m_dir});
            check("R2 pin_out", {24'h0, pin_out}, {24'h0, m_out});
            check("R8 irq", {31'h0, irq}, {31'h0, |(m_pend & m_ien)});
            check("R9 trig", {31'h0, trig}, {31'h0, m_trig});
            check("R10 rdata", bus_rdata, m_read(int'(bus_addr)));
        end
        if (cyc > 50000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_strb = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        check("R1 oe", {24'h0, pin_oe}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(0, 32'h0, "R1 dir");
        rd(8, 32'h0, "R1 tsel");
        // R2 direction and output data
        wr(0, 32'h0000_00F0, 4'hF);
        rd(0, 32'hF0, "R2 dir");
        check("R2 oe", {24'h0, pin_oe}, 32'hF0);
        wr(1, 32'h5A, 4'h1);
        rd(1, 32'h5A, "R2 out");
        // R3 set
        wr(2, 32'h81, 4'h1);
        rd(1, 32'hDB, "R3 out");
        rd(2, 32'h0, "R3 read");
        // R4 clear
        wr(3, 32'h18, 4'h1);
        rd(1, 32'hC3, "R4 out");
        rd(3, 32'h0, "R4 read");
        // R10 lanes and unmapped addresses
        wr(1, 32'hFFFF_FFFF, 4'hE);
        rd(1, 32'hC3, "R10 lane");
        wr(9, 32'hFF, 4'hF);
        rd(9, 32'h0, "R10 unmapped");
        // R5 synchronizer latency
        @(negedge clk); pin_in = 8'h3C;
        rd(4, 32'h0, "R5 early");
        rd(4, 32'h3C, "R5 synced");
        // R6 rising-edge pending, R8 masking
        idle(3);
        rd(7, 32'h3C, "R6 rise");
        check("R8 masked", {31'h0, irq}, 32'h0);
        wr(6, 32'h04, 4'h1);
        check("R8 irq on", {31'h0, irq}, 32'h1);
        wr(7, 32'h3C, 4'h1);
        rd(7, 32'h0, "R7 w1c");
        check("R8 irq off", {31'h0, irq}, 32'h0);
        // R6 falling select
        wr(5, 32'h01, 4'h1);
        @(negedge clk); pin_in = 8'h3D;
        idle(4);
        rd(7, 32'h0, "R6 wrong edge");
        @(negedge clk); pin_in = 8'h3C;
        idle(4);
        rd(7, 32'h01, "R6 fall");
        wr(7, 32'h01, 4'h1);
        // R9 trigger on pin 3
        wr(8, 32'h3, 4'h1);
        @(negedge clk); pin_in = 8'h34;
        idle(4);
        rd(7, 32'h0, "R6 no fall event");
        @(negedge clk); pin_in = 8'h3C;
        @(posedge clk); @(posedge clk); #1;
        check("R9 before", {31'h0, trig}, 32'h0);
        @(posedge clk); #1;
        check("R9 pulse", {31'h0, trig}, 32'h1);
        @(posedge clk); #1;
        check("R9 after", {31'h0, trig}, 32'h0);
        rd(7, 32'h08, "R6 pend3");
        // R7 clear racing a new event
        @(negedge clk); pin_in = 8'h34;
        idle(4);
        @(negedge clk); pin_in = 8'h3C;
        @(negedge clk);
        wr(7, 32'h08, 4'h1);
        rd(7, 32'h08, "R7 race");
        wr(7, 32'h00, 4'h1);
        rd(7, 32'h08, "R7 zero");
        wr(7, 32'h08, 4'h1);
        rd(7, 32'h0, "R7 clear");
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule